// File: doc/BRIEF.md
# Page-Table Translation Unit

The unit turns a 32-bit virtual address into a 24-bit physical address by looking up one entry of a single-level page table. Each request carries an address and an access kind (read, write or instruction fetch). The unit adds the virtual page number to a table base register to form the entry address. It issues one read on a memory port with a one-cycle latency. It then reports either the translated address or a fault code.

A fault is reported separately for two causes. One is an entry that is not resident. The other is a resident entry whose rights forbid the access. Loading a new value into the base register points the unit at another table, and so switches the active address space. Only one lookup is in progress at a time.

Top module: `vaddr_xlate`

## Requirements
- R1: A successful translation returns phys_addr = {entry bits 11:0, req_vaddr[11:0]}: the low 12 offset bits pass through unchanged, and the entry's page number forms bits 23:12. fault_type is 00.
- R2: In the acceptance cycle, mem_rd_en is high and mem_rd_addr = (table base + req_vaddr[31:12]) modulo 2^16. mem_rd_en is low in every other cycle.
- R3: An entry is decoded as follows: bit 15 is the resident flag, bits 13:12 are the rights, and bits 11:0 are the physical page number. Bit 14 has no effect on the result.
- R4: An entry with bit 15 clear gives fault_type 01 and phys_addr 0, whatever its rights are.
- R5: The access kinds are 00 read, 01 write and 10 fetch. The rights codes are 00 read-only, 01 read/write and 10 execute-only. A read is allowed under 00 or 01, a write only under 01, and a fetch only under 10. Any other resident access gives fault_type 10 and phys_addr 0.
- R6: A resident entry with rights 11 always gives fault_type 10, and so does access kind 11.
- R7: req_ready is high while idle. A request is accepted on req_valid && req_ready. req_ready is then low for exactly one cycle. done is a one-cycle pulse in the following cycle, during which req_ready is high again.
- R8: When ptbr_wr is high at a clock edge, the base register loads ptbr_wdata. A request accepted at that same edge still uses the old base, and every later request uses the new one.
- R9: After reset, req_ready is 1, done is 0 and the table base is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| ptbr_wr | input | 1 | Load the table base register |
| ptbr_wdata | input | 16 | New table base |
| mem_rd_en | output | 1 | Entry read strobe |
| mem_rd_addr | output | 16 | Entry address |
| mem_rd_data | input | 16 | Entry, valid one cycle after the strobe |
| done | output | 1 | Result pulse |
| fault_type | output | 2 | 00 none, 01 not resident, 10 protection |
| phys_addr | output | 24 | Translated address, 0 on a fault |

## Verification
On every cycle, the checker enforces the handshake shape: one busy cycle after each acceptance, then a done pulse. It also checks that reads are issued only at acceptance, that no fault code is 11, and that a faulting result carries a zero address. Three things can only be shown by the bench's scenarios, where a behavioural model computes each result from the table contents: the rights matrix across all kinds and codes, the offset pass-through, and the wraparound of the entry address. The same holds for the timing of a base register update that coincides with an acceptance, and for a request held valid back to back.

// File: rtl/vaddr_xlate.sv
module vaddr_xlate #(
  parameter int OFF_W = 12,
  parameter int VPN_W = 20,
  parameter int PPN_W = 12,
  parameter int TAW   = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [OFF_W+VPN_W-1:0] req_vaddr,
  input  logic [1:0]             req_kind,
  input  logic                   ptbr_wr,
  input  logic [TAW-1:0]         ptbr_wdata,
  output logic                   mem_rd_en,
  output logic [TAW-1:0]         mem_rd_addr,
  input  logic [15:0]            mem_rd_data,
  output logic                   done,
  output logic [1:0]             fault_type,
  output logic [PPN_W+OFF_W-1:0] phys_addr
);
  localparam int V_BIT = 15;
  localparam int R_LO  = 12;

  logic [TAW-1:0]   ptbr;
  logic             busy;
  logic [1:0]       kind_q;
  logic [OFF_W-1:0] off_q;
  logic             allowed;

  wire       pte_v  = mem_rd_data[V_BIT];
  wire [1:0] rights = mem_rd_data[R_LO+1:R_LO];

  assign req_ready   = !busy;
  assign mem_rd_en   = req_valid && !busy;
  assign mem_rd_addr = ptbr + TAW'(req_vaddr[OFF_W +: VPN_W]);

  always_comb begin
    case (kind_q)
      2'b00:   allowed = (rights == 2'b00) || (rights == 2'b01);
      2'b01:   allowed = (rights == 2'b01);
      2'b10:   allowed = (rights == 2'b10);
      default: allowed = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptbr       <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      fault_type <= 2'b00;
      phys_addr  <= '0;
      kind_q     <= 2'b00;
      off_q      <= '0;
    end else begin
      done <= busy;
      busy <= mem_rd_en;
      if (mem_rd_en) begin
        kind_q <= req_kind;
        off_q  <= req_vaddr[OFF_W-1:0];
      end
      if (busy) begin
        if (!pte_v) begin
          fault_type <= 2'b01;
          phys_addr  <= '0;
        end else if (!allowed) begin
          fault_type <= 2'b10;
          phys_addr  <= '0;
        end else begin
          fault_type <= 2'b00;
          phys_addr  <= {mem_rd_data[PPN_W-1:0], off_q};
        end
      end
      if (ptbr_wr) ptbr <= ptbr_wdata;
    end
  end
endmodule

// File: rtl/vaddr_xlate_chk.sv
module vaddr_xlate_chk #(
  parameter int PA_W = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_rd_en,
  input logic            done,
  input logic [1:0]      fault_type,
  input logic [PA_W-1:0] phys_addr
);
  assert_accept_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  assert_busy_then_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready && done);

  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!req_ready));

  assert_read_on_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> req_ready && req_valid);

  assert_code_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> fault_type != 2'b11);

  assert_fault_zero_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault_type != 2'b00 |-> phys_addr == '0);
endmodule

bind vaddr_xlate vaddr_xlate_chk #(.PA_W(PPN_W+OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_rd_en(mem_rd_en), .done(done), .fault_type(fault_type),
  .phys_addr(phys_addr));

// File: tb/vaddr_xlate_test.sv
`timescale 1ns/1ps
module vaddr_xlate_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [31:0] req_vaddr = 0;
  logic [1:0]  req_kind = 0;
  logic        ptbr_wr = 0;
  logic [15:0] ptbr_wdata = 0;
  logic        mem_rd_en;
  logic [15:0] mem_rd_addr;
  logic [15:0] mem_rd_data = 0;
  logic        done;
  logic [1:0]  fault_type;
  logic [23:0] phys_addr;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  vaddr_xlate uut (.*);

  logic [15:0] pt [int];

  function automatic logic [15:0] pt_get(input logic [15:0] a);
    return pt.exists(int'(a)) ? pt[int'(a)] : 16'h0000;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= pt_get(mem_rd_addr);

  // behavioural reference
  bit          m_busy = 0, m_done = 0, touched = 0, acc;
  logic [15:0] m_ptbr = 0, p_addr = 0, e;
  logic [1:0]  p_kind = 0, m_fault = 0, r;
  logic [11:0] p_off = 0;
  logic [23:0] m_pa = 0;
  bit          ok;
  string       m_tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_ptbr = 0; touched = 0;
    end else begin
      acc = req_valid && !m_busy;
      m_done = 0;
      if (m_busy) begin
        e = pt_get(p_addr);
        r = e[13:12];
        m_done = 1;
        m_busy = 0;
        if (e[15] == 0) begin
          m_fault = 2'b01; m_pa = 0; m_tag = "R4";
        end else begin
          ok = (p_kind == 0 && r < 2) || (p_kind == 1 && r == 1) || (p_kind == 2 && r == 2);
          if (ok) begin
            m_fault = 0; m_pa = {e[11:0], p_off}; m_tag = e[14] ? "R3" : "R1";
          end else begin
            m_fault = 2'b10; m_pa = 0;
            m_tag = (r == 3 || p_kind == 3) ? "R6" : "R5";
          end
        end
      end
      if (acc) begin
        p_addr = m_ptbr + req_vaddr[27:12];
        p_kind = req_kind;
        p_off  = req_vaddr[11:0];
        m_busy = 1;
      end
      if (ptbr_wr) begin m_ptbr = ptbr_wdata; touched = 1; end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R9", req_ready, 1);
      chk("R9", done, 0);
    end else begin
      chk("R7", req_ready, !m_busy);
      chk("R7", done, m_done);
      chk("R2", mem_rd_en, req_valid && !m_busy);
      if (req_valid && !m_busy)
        chk(touched ? "R8" : "R2", mem_rd_addr, 16'(m_ptbr + req_vaddr[27:12]));
      if (m_done) begin
        chk(m_tag, fault_type, m_fault);
        chk(m_tag, phys_addr, m_pa);
      end
    end
  end

  task automatic xlate(input logic [31:0] va, input logic [1:0] k);
    @(posedge clk); #1;
    req_valid = 1; req_vaddr = va; req_kind = k;
    @(posedge clk); #1;
    req_valid = 0;
    @(posedge clk);
    @(posedge clk);
  endtask

  task automatic set_base(input logic [15:0] b);
    @(posedge clk); #1;
    ptbr_wr = 1; ptbr_wdata = b;
    @(posedge clk); #1;
    ptbr_wr = 0;
  endtask

  function automatic logic [15:0] pte(input bit v, input bit x, input logic [1:0] rr,
                                      input logic [11:0] ppn);
    return {v, x, rr, ppn};
  endfunction

  initial begin
    #(4 * 20000);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    pt[16'h0010] = pte(1, 0, 2'b00, 12'hA11); // read-only
    pt[16'h0011] = pte(1, 0, 2'b01, 12'hB22); // read/write
    pt[16'h0012] = pte(1, 0, 2'b10, 12'hC33); // execute-only
    pt[16'h0013] = pte(0, 0, 2'b01, 12'hD44); // not resident
    pt[16'h0014] = pte(1, 0, 2'b11, 12'hE55); // reserved rights
    pt[16'h0015] = pte(1, 1, 2'b01, 12'hF66); // bit 14 set
    pt[16'h2345] = pte(1, 0, 2'b01, 12'h777);
    pt[16'h0110] = pte(1, 0, 2'b01, 12'h888);
    pt[16'h0010 + 16'h0100] = pte(1, 0, 2'b01, 12'h888);
    pt[16'h0115] = pte(1, 0, 2'b10, 12'h999);
    pt[16'h0005] = pte(1, 0, 2'b00, 12'h123);

    xlate(32'h0001_0ABC, 2'b00); // R1 R9 base 0
    xlate(32'h0001_0FFF, 2'b01); // R5 write to read-only
    xlate(32'h0001_1000, 2'b01); // R1 write rw
    xlate(32'h0001_1234, 2'b00); // R5 read rw ok
    xlate(32'h0001_1234, 2'b10); // R5 fetch rw
    xlate(32'h0001_2777, 2'b10); // R1 fetch exec
    xlate(32'h0001_2777, 2'b00); // R5 read exec
    xlate(32'h0001_3001, 2'b00); // R4
    xlate(32'h0001_4002, 2'b00); // R6 reserved rights
    xlate(32'h0001_1003, 2'b11); // R6 reserved kind
    xlate(32'h0001_5ABC, 2'b01); // R3 bit 14 ignored
    xlate(32'h1234_5678, 2'b00); // R2 upper vpn bits dropped
    xlate(32'h0000_0000, 2'b00); // R4 absent entry

    set_base(16'h0100);          // R8
    xlate(32'h0001_0123, 2'b00);
    xlate(32'h0001_5FED, 2'b10);

    // R8: base write at the same edge as an acceptance
    @(posedge clk); #1;
    req_valid = 1; req_vaddr = 32'h0001_0456; req_kind = 2'b00;
    ptbr_wr = 1; ptbr_wdata = 16'hFFF0;
    @(posedge clk); #1;
    req_valid = 0; ptbr_wr = 0;
    @(posedge clk);
    @(posedge clk);
    xlate(32'h0001_5321, 2'b00); // R2 wrap: FFF0+15 -> 0005

    // R7: valid held across several lookups
    @(posedge clk); #1;
    req_valid = 1; req_vaddr = 32'h0001_5010; req_kind = 2'b00;
    repeat (6) @(posedge clk);
    #1 req_valid = 0;
    repeat (3) @(posedge clk);

    #1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule